// File: doc/BRIEF.md
# Power-Up Strap Capture and CPU-to-PCI Ratio Divider

This block reads a 4-bit frequency-select code and a mode strap from dual-purpose pads once, shortly after reset is released. While it waits, every shared pad stays an input. Once it has the values, it asserts the output enables so that the pads can carry clocks from then on. The mode strap decides one more pad. With mode 1 that pad becomes a reference clock output. With mode 0 it stays an input and serves as the PCI stop control.

The held select code maps to a CPU-to-PCI divide ratio of 2, 3 or 4. The block divides the CPU clock input by that ratio to make the PCI clock. Software can replace the strapped code through a write port driven by a serial register interface. Any resulting ratio change waits for the next rising edge of the PCI clock, so no period is ever cut short. The odd ratio uses both CPU clock edges, which gives a 50% duty cycle.

A pad with no external strap on it is reported as open by the pad ring. The block then applies the pad's pull default: 0 for the most significant select bit, 1 for every other strap.

Top module: `strap_ratio_top`

## Requirements
- R1: While rst_n is low, strap_done_o, sel_oe_o (all bits), ref_oe_o and pclk_o are all 0.
- R2: The straps are captured on the 8th rising edge of clk_cpu after rst_n is released. strap_done_o is 0 after edges 1 to 7 and 1 after edge 8. It then stays 1 until the next reset.
- R3: sel_oe_o is 4'b0000 before capture and 4'b1111 after it. ref_oe_o becomes 1 after capture only if the captured mode is 1 (reference clock output). A captured mode of 0 keeps ref_oe_o at 0 (the pad stays the PCI stop input). mode_o shows the captured mode.
- R4: When a pad is reported open, the captured value of that strap is the pull default: bit 3 of the select code is 0, and bits 2:0 and the mode are 1.
- R5: After capture, changes on sel_pin_i, sel_open_i, mode_pin_i and mode_open_i have no effect on mode_o, ratio_o or the PCI clock until the next reset.
- R6: Select code (bit 3 first) 1100 to 1111 gives ratio 4. Codes 0001 to 0011 give ratio 2. Code 0000 and codes 0100 to 1011 give ratio 3. ratio_o shows the applied ratio as an unsigned number.
- R7: pclk_o has a period of exactly N clk_cpu cycles, where N is the applied ratio. It is high for N/2 cycles: 1, 1.5 or 2 cycles. Its rising edges follow rising edges of clk_cpu.
- R8: A clk_cpu edge with ovr_valid_i high after capture replaces the held code with ovr_code_i. Writes made before capture are ignored.
- R9: A new ratio takes effect only at a pclk_o rising edge. The period during which an override is written keeps the old ratio, and the next period uses the new ratio.
- R10: pclk_o stays low until capture has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU clock, the source of the divided clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pin_i | input | 4 | Select strap values seen at the shared pads |
| sel_open_i | input | 4 | Per-pad flag: select pad has no external strap |
| mode_pin_i | input | 1 | Mode strap value at its pad |
| mode_open_i | input | 1 | Mode pad has no external strap |
| ovr_valid_i | input | 1 | Override write strobe from the register interface |
| ovr_code_i | input | 4 | Override select code |
| sel_oe_o | output | 4 | Output enables for the four select pads |
| ref_oe_o | output | 1 | Output enable for the reference-or-stop pad |
| mode_o | output | 1 | Captured mode strap |
| strap_done_o | output | 1 | Straps have been captured |
| ratio_o | output | 3 | Applied CPU-to-PCI divide ratio |
| pclk_o | output | 1 | Divided PCI clock |

## Verification
The bench counts clock edges from reset release to strap_done_o. A capture that comes one edge early or late, or that samples again later, shows up as a wrong edge count or as a mode and ratio that follow the pads after they change. It measures the period and the high time of pclk_o for all 16 select codes, in half-cycle steps. A decoder with a wrong table boundary, or an odd-ratio path that uses only one clock edge, gives a wrong period or a 1-versus-2 cycle high time. Open-pad cases with bit 3 and the low bits left floating catch a swapped pull default. An override written in the middle of a period checks that the period in progress still has the old length, which a design that switches at once would cut short.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int SEL_W   = 4;
  localparam int RATIO_W = 3;

  // pull defaults for open pads: MSB select bit pulls low, the rest high
  localparam logic [SEL_W-1:0] SEL_PULL  = 4'b0111;
  localparam logic             MODE_PULL = 1'b1;

  // select code -> CPU/PCI divide ratio
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    logic [RATIO_W-1:0] r;
    if (code[3:2] == 2'b11)                  r = 3'd4;
    else if (code != 4'd0 && code <= 4'd3)   r = 3'd2;
    else                                     r = 3'd3;
    return r;
  endfunction

  // high half-cycles per period is the ratio itself; high full cycles from posedge path
  function automatic logic [RATIO_W-1:0] pos_high(input logic [RATIO_W-1:0] r);
    return r >> 1;
  endfunction

  function automatic logic resolve(input logic pin, input logic open_pad, input logic pull);
    return open_pad ? pull : pin;
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_pin,
  input  logic [SEL_W-1:0] sel_open,
  input  logic             mode_pin,
  input  logic             mode_open,
  input  logic             ovr_valid,
  input  logic [SEL_W-1:0] ovr_code,
  output logic             done_o,
  output logic             mode_o,
  output logic [SEL_W-1:0] code_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0]    settle_q;
  logic             done_q;
  logic             mode_q;
  logic [SEL_W-1:0] code_q;
  logic [SEL_W-1:0] sel_res;
  logic             capture_now;

  genvar gi;
  generate
    for (gi = 0; gi < SEL_W; gi++) begin : g_pad
      assign sel_res[gi] = resolve(sel_pin[gi], sel_open[gi], SEL_PULL[gi]);
    end
  endgenerate

  assign capture_now = !done_q && (settle_q == CW'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      done_q   <= 1'b0;
      mode_q   <= 1'b0;
      code_q   <= '0;
    end else if (!done_q) begin
      settle_q <= settle_q + 1'b1;
      if (capture_now) begin
        done_q <= 1'b1;
        mode_q <= resolve(mode_pin, mode_open, MODE_PULL);
        code_q <= sel_res;
      end
    end else if (ovr_valid) begin
      code_q <= ovr_code;
    end
  end

  assign done_o = done_q;
  assign mode_o = mode_q;
  assign code_o = code_q;

  // R2
  capture_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_now |=> (done_q && !capture_now));
  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable(mode_q));
  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ovr_valid) |=> $stable(code_q));
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio_req,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               pclk_o
);
  logic               run_q;
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               hi_q, hi_n;
  logic               wrap;

  assign wrap    = !run_q || (cnt_q == ratio_q - 1'b1);
  assign cnt_d   = wrap ? '0 : cnt_q + 1'b1;
  assign ratio_d = wrap ? ratio_req : ratio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= 3'd2;
      hi_q    <= 1'b0;
    end else if (!en) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      hi_q    <= (cnt_d < pos_high(ratio_d));
    end
  end

  // half-cycle extension for odd ratios
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hi_n <= 1'b0;
    else        hi_n <= hi_q;
  end

  assign pclk_o  = hi_q | (ratio_q[0] & hi_n);
  assign ratio_o = ratio_q;

  // R9
  ratio_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap) |=> $stable(ratio_q));
  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < ratio_q));
  // R6
  ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q >= 3'd2) && (ratio_q <= 3'd4));
endmodule

// File: rtl/strap_ratio_top.sv
module strap_ratio_top
  import strap_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic         clk_cpu,
  input  logic         rst_n,
  input  logic [3:0]   sel_pin_i,
  input  logic [3:0]   sel_open_i,
  input  logic         mode_pin_i,
  input  logic         mode_open_i,
  input  logic         ovr_valid_i,
  input  logic [3:0]   ovr_code_i,
  output logic [3:0]   sel_oe_o,
  output logic         ref_oe_o,
  output logic         mode_o,
  output logic         strap_done_o,
  output logic [2:0]   ratio_o,
  output logic         pclk_o
);
  logic             done;
  logic             mode_cap;
  logic [SEL_W-1:0] code;
  logic [RATIO_W-1:0] ratio_req;

  strap_capture #(.SETTLE_CYC(SETTLE_CYC)) cap_i (
    .clk       (clk_cpu),
    .rst_n     (rst_n),
    .sel_pin   (sel_pin_i),
    .sel_open  (sel_open_i),
    .mode_pin  (mode_pin_i),
    .mode_open (mode_open_i),
    .ovr_valid (ovr_valid_i),
    .ovr_code  (ovr_code_i),
    .done_o    (done),
    .mode_o    (mode_cap),
    .code_o    (code)
  );

  assign ratio_req = ratio_of(code);

  ratio_divider div_i (
    .clk       (clk_cpu),
    .rst_n     (rst_n),
    .en        (done),
    .ratio_req (ratio_req),
    .ratio_o   (ratio_o),
    .pclk_o    (pclk_o)
  );

  assign sel_oe_o     = {SEL_W{done}};
  assign ref_oe_o     = done & mode_cap;
  assign mode_o       = mode_cap;
  assign strap_done_o = done;

  // R3
  oe_gate_chk: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    !done |-> (sel_oe_o == 4'b0000 && !ref_oe_o));
  // R10
  pclk_idle_chk: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    !done |-> !pclk_o);
endmodule

// File: tb/strap_ratio_tb.sv
`timescale 1ns/1ps
module strap_ratio_top_tb_top;
  logic       clk_cpu = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel_pin_i = 4'd0, sel_open_i = 4'd0, ovr_code_i = 4'd0;
  logic       mode_pin_i = 1'b0, mode_open_i = 1'b0, ovr_valid_i = 1'b0;
  logic [3:0] sel_oe_o;
  logic       ref_oe_o, mode_o, strap_done_o, pclk_o;
  logic [2:0] ratio_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_cpu = ~clk_cpu;

  strap_ratio_top dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [3:0] c);
    case (c)
      4'b1100, 4'b1101, 4'b1110, 4'b1111: return 4;
      4'b0001, 4'b0010, 4'b0011:          return 2;
      default:                            return 3;
    endcase
  endfunction

  task automatic half_step(output logic v);
    @(clk_cpu);
    #1;
    v = pclk_o;
  endtask

  // period and high time in half-cycles, from one pclk rise to the next
  task automatic measure(output int halfs, output int highs);
    logic prev, cur;
    int guard;
    prev = pclk_o; guard = 0;
    half_step(cur);
    while (!(prev == 1'b0 && cur == 1'b1) && guard < 40) begin
      prev = cur; half_step(cur); guard++;
    end
    halfs = 1; highs = 1; prev = cur; guard = 0;
    half_step(cur);
    while (!(prev == 1'b0 && cur == 1'b1) && guard < 40) begin
      halfs++; highs += cur; prev = cur; half_step(cur); guard++;
    end
  endtask

  task automatic do_reset(input logic [3:0] pins, input logic [3:0] opens,
                          input logic m, input logic mopen);
    rst_n = 1'b0;
    sel_pin_i = pins; sel_open_i = opens; mode_pin_i = m; mode_open_i = mopen;
    ovr_valid_i = 1'b0;
    repeat (3) @(posedge clk_cpu);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic t_reset_and_capture();
    do_reset(4'b1100, 4'b0000, 1'b1, 1'b0);
    rst_n = 1'b0; #2;
    check("R1 done in reset", strap_done_o, 0);
    check("R1 sel_oe in reset", sel_oe_o, 0);
    check("R1 ref_oe in reset", ref_oe_o, 0);
    check("R1 pclk in reset", pclk_o, 0);
    @(posedge clk_cpu); #1; rst_n = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      @(posedge clk_cpu); #1;
      check("R2 not yet captured", strap_done_o, 0);
      check("R10 pclk idle", pclk_o, 0);
      check("R3 sel_oe before capture", sel_oe_o, 0);
    end
    @(posedge clk_cpu); #1;
    check("R2 captured at edge 8", strap_done_o, 1);
    check("R3 sel_oe after capture", sel_oe_o, 15);
    check("R3 ref_oe mode1", ref_oe_o, 1);
    check("R3 mode_o", mode_o, 1);
    repeat (20) @(posedge clk_cpu); #1;
    check("R2 done sticky", strap_done_o, 1);
    check("R6 strapped 1100", ratio_o, 4);
  endtask

  task automatic t_mode_stop();
    do_reset(4'b0010, 4'b0000, 1'b0, 1'b0);
    repeat (12) @(posedge clk_cpu); #1;
    check("R3 ref_oe mode0", ref_oe_o, 0);
    check("R3 mode_o mode0", mode_o, 0);
    check("R6 strapped 0010", ratio_o, 2);
  endtask

  task automatic t_open_pads();
    do_reset(4'b1111, 4'b1111, 1'b0, 1'b1);
    repeat (12) @(posedge clk_cpu); #1;
    check("R4 all open -> 0111", ratio_o, 3);
    check("R4 mode open -> 1", mode_o, 1);
    do_reset(4'b1100, 4'b1000, 1'b0, 1'b0);
    repeat (12) @(posedge clk_cpu); #1;
    check("R4 bit3 open -> 0100", ratio_o, 3);
    do_reset(4'b0000, 4'b0011, 1'b0, 1'b0);
    repeat (12) @(posedge clk_cpu); #1;
    check("R4 low bits open -> 0011", ratio_o, 2);
  endtask

  task automatic t_pins_ignored();
    do_reset(4'b0001, 4'b0000, 1'b0, 1'b0);
    repeat (12) @(posedge clk_cpu); #1;
    sel_pin_i = 4'b1111; mode_pin_i = 1'b1; sel_open_i = 4'b1111; mode_open_i = 1'b1;
    repeat (20) @(posedge clk_cpu); #1;
    check("R5 ratio after pin change", ratio_o, 2);
    check("R5 mode after pin change", mode_o, 0);
    check("R5 ref_oe after pin change", ref_oe_o, 0);
  endtask

  task automatic t_early_write();
    do_reset(4'b0000, 4'b0000, 1'b1, 1'b0);
    @(posedge clk_cpu); #1;
    ovr_valid_i = 1'b1; ovr_code_i = 4'b1111;
    repeat (3) @(posedge clk_cpu); #1;
    ovr_valid_i = 1'b0;
    repeat (15) @(posedge clk_cpu); #1;
    check("R8 early write ignored", ratio_o, 3);
  endtask

  task automatic t_all_codes();
    int h, hi;
    do_reset(4'b0000, 4'b0000, 1'b1, 1'b0);
    repeat (12) @(posedge clk_cpu); #1;
    for (int c = 0; c < 16; c++) begin
      ovr_valid_i = 1'b1; ovr_code_i = 4'(c);
      @(posedge clk_cpu); #1;
      ovr_valid_i = 1'b0;
      measure(h, hi);
      measure(h, hi);
      check($sformatf("R6 R8 ratio code %0d", c), ratio_o, exp_ratio(4'(c)));
      check($sformatf("R7 period code %0d", c), h, 2 * exp_ratio(4'(c)));
      check($sformatf("R7 high code %0d", c), hi, exp_ratio(4'(c)));
    end
  endtask

  task automatic t_midperiod_switch();
    logic prev, cur;
    int halfs, guard, h, hi;
    do_reset(4'b1111, 4'b0000, 1'b1, 1'b0);
    repeat (12) @(posedge clk_cpu); #1;
    measure(h, hi);
    check("R7 ratio4 period", h, 8);
    // wait for a rise, then write ratio-2 code inside that period
    prev = pclk_o; guard = 0;
    half_step(cur);
    while (!(prev == 1'b0 && cur == 1'b1) && guard < 40) begin
      prev = cur; half_step(cur); guard++;
    end
    ovr_valid_i = 1'b1; ovr_code_i = 4'b0001;
    halfs = 1; prev = cur; guard = 0;
    half_step(cur);
    while (!(prev == 1'b0 && cur == 1'b1) && guard < 40) begin
      if (clk_cpu) ovr_valid_i = 1'b0;
      halfs++; prev = cur; half_step(cur); guard++;
    end
    ovr_valid_i = 1'b0;
    check("R9 period during write keeps old ratio", halfs, 8);
    measure(h, hi);
    check("R9 next period uses new ratio", h, 4);
  endtask

  initial begin
    t_reset_and_capture();
    t_mode_stop();
    t_open_pads();
    t_pins_ignored();
    t_early_write();
    t_all_codes();
    t_midperiod_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule